// File: doc/BRIEF.md
# GPIO Pin Level Resolver

This block works out the electrical level of every pin in a bank of general-purpose I/O pins. Each pin can have three kinds of source: the bank's own output driver, an external driver, and the internal pull resistors. The own driver is set by a data-out bit, an inversion bit and an output-enable bit. A per-pin open-drain select lets the driver pull low but never push high. The external driver is given as a per-pin "driving" flag and a level bit, and both are sampled on every clock. When a pin has no driver at all, the pull-up or pull-down setting decides its level.

Each cycle the block registers four vectors. The first is the resolved level of each pin. The second is an undefined flag for pins that are fought over by opposing drivers or that float with no pull. The third is the input word seen by software: the resolved level is gated by an input mask, then passed through the same inversion bit used on the output side. The fourth is a change vector for a downstream event detector. The block also reports which pins need their outgoing level re-sent. Every output appears one clock after the inputs that produce it.

Top module: `pin_level_resolver`

## Requirements
- R1: The bank's own drive level for pin i is `dout[i] XOR inv[i]`. With `oe[i]=1`, `odrain[i]=0` and no external driver, the resolved level equals this value.
- R2: The own driver is active on pin i only when `oe[i]=1`, and not when `odrain[i]=1` and the drive level is 1. An open-drain pin that should go high is therefore left to the pulls or to the external driver.
- R3: If pin i is driven both by the own driver and by the external driver, and the two levels differ, `pin_undef[i]` is 1.
- R4: The resolved level is 1 in three cases: the external driver is active with level 1; the own driver is active with level 1; or neither driver is active and `pull_up[i]=1`. In every other case it is 0. `ext_lvl[i]` has no effect while `ext_drv[i]=0`.
- R5: An undriven pin with neither pull enabled is flagged undefined and reads as level 0. With only `pull_dn[i]=1` it resolves to 0 and is not flagged. With both pulls set, the pull-up wins.
- R6: `din` is `(resolved level AND in_mask) XOR inv`, registered with the resolved level.
- R7: `din_delta` is the XOR of the previous registered `din` and the new one.
- R8: `pin_chg[i]` is 1 when pin i's resolved level differs from its previous registered value, or when pin i is undefined and `upd_mask[i]=1`.
- R9: While `rst_n` is low, all outputs are 0. Each output reflects the inputs sampled at the preceding rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dout | input | NPINS | Data-out bits of the own driver |
| inv | input | NPINS | Per-pin inversion, applied to output and input paths |
| oe | input | NPINS | Output enable of the own driver |
| odrain | input | NPINS | Open-drain select (1 = drive low only) |
| pull_up | input | NPINS | Internal pull-up enable |
| pull_dn | input | NPINS | Internal pull-down enable |
| in_mask | input | NPINS | Input enable mask for the data-in word |
| ext_drv | input | NPINS | External driver active flag |
| ext_lvl | input | NPINS | External driver level |
| upd_mask | input | NPINS | Pins whose undefined state forces a change flag |
| pin_lvl | output | NPINS | Registered resolved pin level |
| pin_undef | output | NPINS | Registered contention-or-floating flag |
| pin_chg | output | NPINS | Registered output-change flag |
| din | output | NPINS | Registered data-in word |
| din_delta | output | NPINS | Previous data-in XOR current data-in |

## Verification
Directed patterns test one source at a time: the own push-pull driver with and without inversion, an open-drain pin asked to go high with each pull setting, a contention between the own and external drivers, and floating pins under each pull combination. These show whether drive suppression, pull priority and undefined flagging are each correct. Long random runs then mix all the controls at once, so a wrong term in the level merge, the input-side inversion, the change vector or the update-mask path shows up as a mismatch against an independent bench model. Holding the inputs steady between random steps tells a true level change apart from a change flag that is raised only because of the update mask.

// File: rtl/pinres_pkg.sv
package pinres_pkg;

  // Own-driver output level of one pin.
  function automatic logic own_level(input logic d, input logic inv);
    return d ^ inv;
  endfunction

  // Own driver active: enabled, and not an open-drain pin asked to go high.
  function automatic logic own_active(input logic oe, input logic od, input logic lvl);
    return oe & ~(od & lvl);
  endfunction

  // Merge all sources into one level.
  function automatic logic merge_level(input logic xd, input logic xl,
                                       input logic id, input logic il,
                                       input logic pu);
    logic undriven;
    undriven = ~(xd | id);
    return (xd & xl) | (id & il) | (undriven & pu);
  endfunction

  // Contention between the own driver and the external driver.
  function automatic logic clash(input logic xd, input logic xl,
                                 input logic id, input logic il);
    return xd & id & (xl ^ il);
  endfunction

  // Pin with no driver and no pull.
  function automatic logic floating(input logic xd, input logic id,
                                    input logic pu, input logic pd);
    return ~(xd | id) & ~(pu | pd);
  endfunction

  // Input-side view of a pin level.
  function automatic logic sense(input logic lvl, input logic en, input logic inv);
    return (lvl & en) ^ inv;
  endfunction

endpackage

// File: rtl/pinres_drive.sv
module pinres_drive #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] dout,
  input  logic [NPINS-1:0] inv,
  input  logic [NPINS-1:0] oe,
  input  logic [NPINS-1:0] odrain,
  output logic [NPINS-1:0] own_lvl,
  output logic [NPINS-1:0] own_on
);
  import pinres_pkg::*;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign own_lvl[i] = own_level(dout[i], inv[i]);
    assign own_on[i]  = own_active(oe[i], odrain[i], own_lvl[i]);
  end

  // R2: an open-drain pin never pushes a high level
  p_od_no_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((own_on & odrain & own_lvl) == '0));

  // R2: a disabled output is never active
  p_oe_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((own_on & ~oe) == '0));

endmodule

// File: rtl/pinres_merge.sv
module pinres_merge #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] own_lvl,
  input  logic [NPINS-1:0] own_on,
  input  logic [NPINS-1:0] ext_drv,
  input  logic [NPINS-1:0] ext_lvl,
  input  logic [NPINS-1:0] pull_up,
  input  logic [NPINS-1:0] pull_dn,
  output logic [NPINS-1:0] res_lvl,
  output logic [NPINS-1:0] res_undef
);
  import pinres_pkg::*;

  logic [NPINS-1:0] clash_v;
  logic [NPINS-1:0] float_v;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign res_lvl[i] = merge_level(ext_drv[i], ext_lvl[i], own_on[i], own_lvl[i], pull_up[i]);
    assign clash_v[i] = clash(ext_drv[i], ext_lvl[i], own_on[i], own_lvl[i]);
    assign float_v[i] = floating(ext_drv[i], own_on[i], pull_up[i], pull_dn[i]);
  end

  assign res_undef = clash_v | float_v;

  // R4: a pin driven only from outside follows the external level
  p_ext_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (((res_lvl ^ ext_lvl) & ext_drv & ~own_on) == '0));

  // R5: a pin with only the pull-down resolves low and is not undefined
  p_pd_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (((res_lvl | res_undef) & ~ext_drv & ~own_on & pull_dn & ~pull_up) == '0));

  // R3: pins with a single driver are never undefined
  p_single_drv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((res_undef & (ext_drv ^ own_on)) == '0));

endmodule

// File: rtl/pinres_sense.sv
module pinres_sense #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] res_lvl,
  input  logic [NPINS-1:0] in_mask,
  input  logic [NPINS-1:0] inv,
  output logic [NPINS-1:0] din_next
);
  import pinres_pkg::*;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign din_next[i] = sense(res_lvl[i], in_mask[i], inv[i]);
  end

endmodule

// File: rtl/pin_level_resolver.sv
module pin_level_resolver #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] dout,
  input  logic [NPINS-1:0] inv,
  input  logic [NPINS-1:0] oe,
  input  logic [NPINS-1:0] odrain,
  input  logic [NPINS-1:0] pull_up,
  input  logic [NPINS-1:0] pull_dn,
  input  logic [NPINS-1:0] in_mask,
  input  logic [NPINS-1:0] ext_drv,
  input  logic [NPINS-1:0] ext_lvl,
  input  logic [NPINS-1:0] upd_mask,
  output logic [NPINS-1:0] pin_lvl,
  output logic [NPINS-1:0] pin_undef,
  output logic [NPINS-1:0] pin_chg,
  output logic [NPINS-1:0] din,
  output logic [NPINS-1:0] din_delta
);

  logic [NPINS-1:0] own_lvl;
  logic [NPINS-1:0] own_on;
  logic [NPINS-1:0] res_lvl;
  logic [NPINS-1:0] res_undef;
  logic [NPINS-1:0] din_next;
  logic [NPINS-1:0] chg_next;

  pinres_drive #(.NPINS(NPINS)) u_drive (
    .clk(clk), .rst_n(rst_n), .dout(dout), .inv(inv), .oe(oe),
    .odrain(odrain), .own_lvl(own_lvl), .own_on(own_on)
  );

  pinres_merge #(.NPINS(NPINS)) u_merge (
    .clk(clk), .rst_n(rst_n), .own_lvl(own_lvl), .own_on(own_on),
    .ext_drv(ext_drv), .ext_lvl(ext_lvl), .pull_up(pull_up),
    .pull_dn(pull_dn), .res_lvl(res_lvl), .res_undef(res_undef)
  );

  pinres_sense #(.NPINS(NPINS)) u_sense (
    .res_lvl(res_lvl), .in_mask(in_mask), .inv(inv), .din_next(din_next)
  );

  assign chg_next = (res_lvl ^ pin_lvl) | (res_undef & upd_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_lvl   <= '0;
      pin_undef <= '0;
      pin_chg   <= '0;
      din       <= '0;
      din_delta <= '0;
    end else begin
      pin_lvl   <= res_lvl;
      pin_undef <= res_undef;
      pin_chg   <= chg_next;
      din       <= din_next;
      din_delta <= din ^ din_next;
    end
  end

  // R8: every registered level change is accompanied by a change flag
  p_lvl_change_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (((pin_lvl ^ $past(pin_lvl)) & ~pin_chg) == '0));

  // R7: delta matches the step between consecutive data-in words
  p_delta_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (din_delta == (din ^ $past(din))));

  // R6: data-in follows the registered level under last cycle's mask and inversion
  p_din_view_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (din == ((pin_lvl & $past(in_mask)) ^ $past(inv))));

endmodule

// File: tb/pin_level_resolver_tb.sv
module pin_level_resolver_tb;
  localparam int N = 32;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] dout, inv, oe, odrain, pull_up, pull_dn, in_mask, ext_drv, ext_lvl, upd_mask;
  logic [N-1:0] pin_lvl, pin_undef, pin_chg, din, din_delta;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [N-1:0] prev_lvl = '0;
  logic [N-1:0] prev_din = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_level_resolver #(.NPINS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .dout(dout), .inv(inv), .oe(oe), .odrain(odrain),
    .pull_up(pull_up), .pull_dn(pull_dn), .in_mask(in_mask), .ext_drv(ext_drv),
    .ext_lvl(ext_lvl), .upd_mask(upd_mask), .pin_lvl(pin_lvl), .pin_undef(pin_undef),
    .pin_chg(pin_chg), .din(din), .din_delta(din_delta)
  );

  // Bench model: per pin, decided case by case
  function automatic logic [1:0] model_pin(input int i);
    logic want, mine, theirs;
    logic lvl, und;
    want   = inv[i] ? ~dout[i] : dout[i];
    mine   = oe[i] && !(odrain[i] && want);
    theirs = ext_drv[i];
    if (mine && theirs) begin
      lvl = want | ext_lvl[i];
      und = (want != ext_lvl[i]);
    end else if (mine) begin
      lvl = want; und = 1'b0;
    end else if (theirs) begin
      lvl = ext_lvl[i]; und = 1'b0;
    end else if (pull_up[i]) begin
      lvl = 1'b1; und = 1'b0;
    end else if (pull_dn[i]) begin
      lvl = 1'b0; und = 1'b0;
    end else begin
      lvl = 1'b0; und = 1'b1;
    end
    return {und, lvl};
  endfunction

  task automatic cmp(input string req, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Apply current inputs at a falling edge, check after the next rising edge.
  task automatic step(input string tag);
    logic [N-1:0] e_lvl, e_und, e_chg, e_din;
    for (int i = 0; i < N; i++) begin
      logic [1:0] r;
      r = model_pin(i);
      e_lvl[i] = r[0];
      e_und[i] = r[1];
    end
    e_din = '0;
    for (int i = 0; i < N; i++)
      e_din[i] = in_mask[i] ? (e_lvl[i] != inv[i]) : inv[i];
    e_chg = (e_lvl ^ prev_lvl) | (e_und & upd_mask);
    @(posedge clk);
    @(negedge clk);
    cmp({tag, "/R4"}, "pin_lvl", pin_lvl, e_lvl);
    cmp({tag, "/R3R5"}, "pin_undef", pin_undef, e_und);
    cmp({tag, "/R8"}, "pin_chg", pin_chg, e_chg);
    cmp({tag, "/R6"}, "din", din, e_din);
    cmp({tag, "/R7"}, "din_delta", din_delta, e_din ^ prev_din);
    prev_lvl = e_lvl;
    prev_din = e_din;
  endtask

  task automatic quiet();
    dout = '0; inv = '0; oe = '0; odrain = '0; pull_up = '0; pull_dn = '0;
    in_mask = '1; ext_drv = '0; ext_lvl = '0; upd_mask = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    quiet();
    ext_drv = '1; ext_lvl = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset holds every output low even with active inputs
    cmp("R9", "pin_lvl", pin_lvl, '0);
    cmp("R9", "din", din, '0);
    cmp("R9", "pin_chg", pin_chg, '0);
    rst_n = 1'b1;
    quiet();
    pull_dn = '1;
    step("R9");

    // R1: push-pull own drive with mixed inversion
    quiet(); oe = '1; dout = 32'hA5A5_0F0F; inv = 32'hFF00_FF00;
    step("R1");
    cmp("R1", "pin_lvl", pin_lvl, 32'hA5A5_0F0F ^ 32'hFF00_FF00);

    // R2: open drain asked high: floats (undef) without pulls, high with pull-up
    quiet(); oe = '1; odrain = '1; dout = 32'hFFFF_0000;
    step("R2");
    cmp("R2", "pin_undef", pin_undef, 32'hFFFF_0000);
    pull_up = 32'h00FF_0000;
    step("R2");
    cmp("R2", "pin_lvl", pin_lvl, 32'h00FF_0000);
    // R2: open drain low pin opposed by external high is contention
    ext_drv = 32'h0000_0001; ext_lvl = 32'h0000_0001;
    step("R2");
    cmp("R2", "pin_undef", pin_undef & 32'h0000_0001, 32'h0000_0001);

    // R3: contention between own and external drivers
    quiet(); oe = 32'h0000_00FF; dout = 32'h0000_000F; ext_drv = 32'h0000_00FF;
    ext_lvl = 32'h0000_00F0; pull_dn = '1;
    step("R3");
    cmp("R3", "pin_undef", pin_undef, 32'h0000_00FF);

    // R4: external level ignored while not driven
    quiet(); pull_dn = '1; ext_lvl = '1;
    step("R4");
    cmp("R4", "pin_lvl", pin_lvl, '0);

    // R5: float, pull-down only, both pulls
    quiet(); pull_dn = 32'h0000_FFFF; pull_up = 32'h00FF_00FF;
    step("R5");
    cmp("R5", "pin_lvl", pin_lvl, 32'h00FF_00FF);
    cmp("R5", "pin_undef", pin_undef, 32'hFF00_0000);

    // R8: steady undefined pins raise change only under the update mask
    upd_mask = 32'h0F00_0000;
    step("R8");
    cmp("R8", "pin_chg", pin_chg, 32'h0F00_0000);

    // R6: masked input bits read as the inversion bit
    quiet(); ext_drv = '1; ext_lvl = '1; in_mask = 32'h0000_FFFF; inv = 32'h00F0_00F0;
    step("R6");
    cmp("R6", "din", din, 32'h00F0_FF0F);

    // Random mix
    for (int k = 0; k < 3000; k++) begin
      dout = $urandom; inv = $urandom; oe = $urandom; odrain = $urandom;
      pull_up = $urandom & $urandom; pull_dn = $urandom; in_mask = $urandom;
      ext_drv = $urandom & $urandom; ext_lvl = $urandom; upd_mask = $urandom;
      step("RND");
      if (($urandom & 3) == 0) step("RND_HOLD");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule